// File: doc/BRIEF.md
# SDRAM Bank Command Legality Checker

This block watches the command pins of a four-bank synchronous DRAM and checks each command it sees. Every cycle it turns the chip-select, row strobe, column strobe and write-enable levels into a command, and uses CKE to tell the variants apart. It then judges that command against the state of the bank named by the bank-select bits. For every bank it tracks whether the bank is closed, open, in a read burst or in a write burst. A command that is legal moves the addressed bank to its next state. A command that is not legal raises a one-cycle flag with a reason code and changes no bank state.

Three minimum delays are counted in clock cycles and set by parameters: activate to column access, activate to precharge, and activate to activate across banks. The first two are counted per bank and the third is one counter shared by all banks. A read or write burst lasts a parameterized number of cycles. When a burst ends on its own, the bank returns to open, or to closed if the column command had A10 high. A new read, a new write or a precharge cuts a running burst short.

Every output is registered. The outputs seen after a clock edge describe the command sampled at that edge and the bank states that result from it.

Top module: `sdram_cmd_guard`

## Requirements
- R1: With cs_n low, the levels {ras_n,cas_n,we_n} decode as follows. 000 is mode-set (code 2). 001 is refresh (code 3). 010 is precharge (code 4). 011 is activate (code 5). 100 is write (code 6). 101 is read (code 7). 111 is no-op (code 1). 110 is reserved (code 11). With cs_n high the command is deselect (code 0). cmd_o shows the code one clock after the command is sampled.
- R2: While reset is asserted, and after it is released, all banks are closed (state 0), cmd_o is 0, illegal_o is 0 and reason_o is 0. Bank b is reported in bank_state_o[2b+1:2b] with the encoding 0 closed, 1 open, 2 reading, 3 writing.
- R3: For a closed bank, precharge is legal and does nothing. A read or write to a closed bank is illegal with reason 1 (wrong bank state).
- R4: An activate to a closed bank opens it (state 1). An activate to a bank that is open, reading or writing is illegal with reason 1.
- R5: A read or write to an open bank puts the bank in state 2 or 3 for BURST_LEN cycles. After that the bank returns to open if A10 was low, or to closed if A10 was high.
- R6: During a burst, no-op and deselect let the burst continue. A new read or write to that bank restarts the burst with the new direction and the new A10 choice, and this also applies on the burst's last cycle. A precharge ends the burst and closes the bank.
- R7: A read or write that comes fewer than T_RCD cycles after the bank's activate is illegal with reason 3.
- R8: A precharge to a bank that is not closed, issued fewer than T_RAS cycles after that bank's activate, is illegal with reason 4.
- R9: An activate that comes fewer than T_RRD cycles after the previous legal activate to any bank is illegal with reason 5.
- R10: Mode-set and refresh are legal only when all banks are closed. Otherwise they are illegal with reason 2.
- R11: A refresh with CKE low is reported as self-refresh entry (code 8). A deselect with CKE low while all banks are closed is reported as power-down entry (code 9). A cycle whose previous cycle had CKE low is reported as code 10: it is not judged, and it changes no bank state and no burst.
- R12: illegal_o lasts a single cycle for each illegal command. An illegal command changes no bank state. The state of any other bank never makes a command illegal, except under R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the command bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe level |
| cas_n | input | 1 | Column strobe level |
| we_n | input | 1 | Write-enable level |
| ba | input | 2 | Bank select |
| a10 | input | 1 | Address bit 10; on a column command it requests auto precharge |
| cke | input | 1 | Clock-enable level |
| bank_state_o | output | 8 | Two-bit state of each bank |
| cmd_o | output | 4 | Decoded command code |
| illegal_o | output | 1 | One-cycle flag for an illegal command |
| reason_o | output | 3 | Reason for the flag: 0 none, 1 state, 2 banks not closed, 3 RCD, 4 RAS, 5 RRD |

## Verification
Two kinds of event can fall on the same clock edge: a burst reaching its last cycle, which would move the bank back to open or closed by itself, and a new column command to the same bank. To provoke this, the bench issues a read with A10 high exactly on a write-then-read burst's final beat. It then checks that the bank stays in the reading state for a full new burst and afterwards closes, and does not return to open. The same edge-sharing is tested at the activate spacing limit: an activate lands on the exact cycle the shared spacing counter expires and must be accepted, while one cycle earlier it must be flagged with reason 5.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

  typedef enum logic [1:0] {
    BK_IDLE = 2'd0,
    BK_OPEN = 2'd1,
    BK_RD   = 2'd2,
    BK_WR   = 2'd3
  } bank_st_e;

  typedef enum logic [3:0] {
    CM_DESEL = 4'd0,
    CM_NOP   = 4'd1,
    CM_MRS   = 4'd2,
    CM_REF   = 4'd3,
    CM_PRE   = 4'd4,
    CM_ACT   = 4'd5,
    CM_WR    = 4'd6,
    CM_RD    = 4'd7,
    CM_SREF  = 4'd8,
    CM_PDN   = 4'd9,
    CM_SUSP  = 4'd10,
    CM_RSVD  = 4'd11
  } cmd_e;

  typedef enum logic [2:0] {
    RS_NONE  = 3'd0,
    RS_STATE = 3'd1,
    RS_BUSY  = 3'd2,
    RS_RCD   = 3'd3,
    RS_RAS   = 3'd4,
    RS_RRD   = 3'd5
  } reason_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_guard_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic cke,
  input  logic cke_prev,
  input  logic all_idle,
  output cmd_e cmd
);

  always_comb begin
    cmd = CM_NOP;
    if (!cke_prev) begin
      cmd = CM_SUSP;
    end else if (cs_n) begin
      cmd = (!cke && all_idle) ? CM_PDN : CM_DESEL;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b000:  cmd = CM_MRS;
        3'b001:  cmd = cke ? CM_REF : CM_SREF;
        3'b010:  cmd = CM_PRE;
        3'b011:  cmd = CM_ACT;
        3'b100:  cmd = CM_WR;
        3'b101:  cmd = CM_RD;
        3'b110:  cmd = CM_RSVD;
        default: cmd = CM_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdram_dly_cnt.sv
module sdram_dly_cnt #(
  parameter int DELAY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);

  localparam int CW = (DELAY > 1) ? $clog2(DELAY) : 1;
  localparam logic [CW-1:0] LDV = CW'(DELAY - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = LDV;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  generate
    if (DELAY > 1) begin : g_chk
      p_dly_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !done);
    end
  endgenerate

endmodule

// File: rtl/sdram_bank_ctl.sv
module sdram_bank_ctl
  import sdram_guard_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hold,
  input  logic     hit,
  input  cmd_e     cmd,
  input  logic     a10,
  output bank_st_e state,
  output logic     col_ok,
  output logic     pre_ok
);

  localparam int BW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [BW-1:0] BLAST = BW'(BURST_LEN - 1);

  bank_st_e      st_q, st_d;
  logic [BW-1:0] bcnt_q, bcnt_d;
  logic          ap_q, ap_d;
  logic          upd_en;
  logic          act_ld;
  logic          in_burst;

  assign in_burst = (st_q == BK_RD) || (st_q == BK_WR);
  assign act_ld   = hit && (cmd == CM_ACT);
  assign upd_en   = !hold && (hit || in_burst);

  always_comb begin
    st_d   = st_q;
    bcnt_d = bcnt_q;
    ap_d   = ap_q;
    if (hit) begin
      unique case (cmd)
        CM_ACT: st_d = BK_OPEN;
        CM_PRE: st_d = BK_IDLE;
        CM_RD, CM_WR: begin
          st_d   = (cmd == CM_RD) ? BK_RD : BK_WR;
          bcnt_d = BLAST;
          ap_d   = a10;
        end
        default: st_d = st_q;
      endcase
    end else if (in_burst) begin
      if (bcnt_q == '0) st_d = ap_q ? BK_IDLE : BK_OPEN;
      else              bcnt_d = bcnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= BK_IDLE;
      bcnt_q <= '0;
      ap_q   <= 1'b0;
    end else if (upd_en) begin
      st_q   <= st_d;
      bcnt_q <= bcnt_d;
      ap_q   <= ap_d;
    end
  end

  sdram_dly_cnt #(.DELAY(T_RCD)) u_rcd (
    .clk(clk), .rst_n(rst_n), .load(act_ld), .done(col_ok)
  );

  sdram_dly_cnt #(.DELAY(T_RAS)) u_ras (
    .clk(clk), .rst_n(rst_n), .load(act_ld), .done(pre_ok)
  );

  assign state = st_q;

  p_open_from_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    act_ld |-> (st_q == BK_IDLE));

  p_col_when_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && (cmd == CM_RD || cmd == CM_WR)) |-> (st_q != BK_IDLE && col_ok));

  p_burst_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_burst && !hold && !hit && bcnt_q == '0) |=>
      (st_q == BK_IDLE || st_q == BK_OPEN));

  p_hold_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(st_q));

endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
  import sdram_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BURST_LEN = 4,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6,
  parameter int T_RRD     = 2,
  localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   ras_n,
  input  logic                   cas_n,
  input  logic                   we_n,
  input  logic [BA_W-1:0]        ba,
  input  logic                   a10,
  input  logic                   cke,
  output logic [2*NUM_BANKS-1:0] bank_state_o,
  output logic [3:0]             cmd_o,
  output logic                   illegal_o,
  output logic [2:0]             reason_o
);

  logic rs_meta, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_n_s, rs_meta} <= 2'b00;
    else        {rst_n_s, rs_meta} <= {rs_meta, 1'b1};
  end

  logic cke_q;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) cke_q <= 1'b1;
    else          cke_q <= cke;
  end

  bank_st_e             st [NUM_BANKS];
  logic [NUM_BANKS-1:0] col_ok, pre_ok, idle_v, hit;
  logic                 all_idle;
  cmd_e                 cmd_dec;

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) idle_v[b] = (st[b] == BK_IDLE);
  end
  assign all_idle = &idle_v;

  sdram_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cke(cke), .cke_prev(cke_q), .all_idle(all_idle), .cmd(cmd_dec)
  );

  logic rrd_ok, any_act;
  sdram_dly_cnt #(.DELAY(T_RRD)) u_rrd (
    .clk(clk), .rst_n(rst_n_s), .load(any_act), .done(rrd_ok)
  );

  bank_st_e sel_st;
  logic     sel_col_ok, sel_pre_ok;
  logic     ill_d;
  reason_e  rsn_d;
  logic     bank_cmd;

  assign sel_st     = st[ba];
  assign sel_col_ok = col_ok[ba];
  assign sel_pre_ok = pre_ok[ba];

  always_comb begin
    ill_d = 1'b0;
    rsn_d = RS_NONE;
    unique case (cmd_dec)
      CM_MRS, CM_REF, CM_SREF: begin
        if (!all_idle) begin ill_d = 1'b1; rsn_d = RS_BUSY; end
      end
      CM_ACT: begin
        if (sel_st != BK_IDLE) begin ill_d = 1'b1; rsn_d = RS_STATE; end
        else if (!rrd_ok)      begin ill_d = 1'b1; rsn_d = RS_RRD;   end
      end
      CM_RD, CM_WR: begin
        if (sel_st == BK_IDLE) begin ill_d = 1'b1; rsn_d = RS_STATE; end
        else if (!sel_col_ok)  begin ill_d = 1'b1; rsn_d = RS_RCD;   end
      end
      CM_PRE: begin
        if (sel_st != BK_IDLE && !sel_pre_ok) begin ill_d = 1'b1; rsn_d = RS_RAS; end
      end
      default: begin ill_d = 1'b0; rsn_d = RS_NONE; end
    endcase
  end

  assign bank_cmd = (cmd_dec == CM_ACT) || (cmd_dec == CM_RD) ||
                    (cmd_dec == CM_WR)  || (cmd_dec == CM_PRE);
  assign any_act  = (cmd_dec == CM_ACT) && !ill_d;

  genvar gb;
  generate
    for (gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
      assign hit[gb] = bank_cmd && !ill_d && (ba == BA_W'(gb));

      sdram_bank_ctl #(
        .BURST_LEN(BURST_LEN), .T_RCD(T_RCD), .T_RAS(T_RAS)
      ) u_bank (
        .clk(clk), .rst_n(rst_n_s), .hold(cmd_dec == CM_SUSP),
        .hit(hit[gb]), .cmd(cmd_dec), .a10(a10),
        .state(st[gb]), .col_ok(col_ok[gb]), .pre_ok(pre_ok[gb])
      );

      assign bank_state_o[2*gb +: 2] = st[gb];
    end
  endgenerate

  cmd_e    cmd_q;
  logic    ill_q;
  reason_e rsn_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cmd_q <= CM_DESEL;
      ill_q <= 1'b0;
      rsn_q <= RS_NONE;
    end else begin
      cmd_q <= cmd_dec;
      ill_q <= ill_d;
      rsn_q <= rsn_d;
    end
  end

  assign cmd_o     = cmd_q;
  assign illegal_o = ill_q;
  assign reason_o  = rsn_q;

  p_flag_has_reason_r12: assert property (@(posedge clk) disable iff (!rst_n_s)
    illegal_o |-> (reason_o != 3'd0));

  p_busy_cmd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((cmd_o == 4'd2 || cmd_o == 4'd3 || cmd_o == 4'd8) && !illegal_o) |->
      (bank_state_o == '0));

  p_suspend_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd_o == 4'd10) |-> (!illegal_o && bank_state_o == $past(bank_state_o)));

  p_one_hit_r12: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(hit));

endmodule

// File: tb/sdram_cmd_guard_tb.sv
module sdram_cmd_guard_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, ras_n, cas_n, we_n, a10, cke;
  logic [1:0] ba;
  logic [7:0] bank_state_o;
  logic [3:0] cmd_o;
  logic       illegal_o;
  logic [2:0] reason_o;

  always #2 clk = ~clk;

  sdram_cmd_guard u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .cke(cke),
    .bank_state_o(bank_state_o), .cmd_o(cmd_o),
    .illegal_o(illegal_o), .reason_o(reason_o)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  // bus levels {cs_n,ras_n,cas_n,we_n}
  localparam logic [3:0] BN = 4'b0111, BD = 4'b1111, BA = 4'b0011,
                         BR = 4'b0101, BW = 4'b0100, BP = 4'b0010,
                         BF = 4'b0001, BM = 4'b0000;

  // {bus, ba, a10, cke, exp cmd, exp illegal, exp reason, exp states, req}
  localparam int NV = 39;
  localparam logic [27:0] VEC [NV] = '{
    {BN,2'd0,1'b0,1'b1, 4'd1, 1'b0,3'd0,8'h00, 4'd1},  // R1 no-op
    {BD,2'd0,1'b0,1'b1, 4'd0, 1'b0,3'd0,8'h00, 4'd1},  // R1 deselect
    {BP,2'd0,1'b0,1'b1, 4'd4, 1'b0,3'd0,8'h00, 4'd3},  // R3 precharge closed bank
    {BR,2'd0,1'b0,1'b1, 4'd7, 1'b1,3'd1,8'h00, 4'd3},  // R3 read closed bank
    {BA,2'd0,1'b0,1'b1, 4'd5, 1'b0,3'd0,8'h01, 4'd4},  // R4 open bank 0
    {BR,2'd0,1'b0,1'b1, 4'd7, 1'b1,3'd3,8'h01, 4'd7},  // R7 too early
    {BA,2'd1,1'b0,1'b1, 4'd5, 1'b0,3'd0,8'h05, 4'd9},  // R9 exact spacing
    {BP,2'd0,1'b0,1'b1, 4'd4, 1'b1,3'd4,8'h05, 4'd8},  // R8 precharge too early
    {BA,2'd0,1'b0,1'b1, 4'd5, 1'b1,3'd1,8'h05, 4'd4},  // R4 activate open bank
    {BR,2'd0,1'b0,1'b1, 4'd7, 1'b0,3'd0,8'h06, 4'd5},  // R5 read burst
    {BN,2'd0,1'b0,1'b1, 4'd1, 1'b0,3'd0,8'h06, 4'd5},
    {BD,2'd0,1'b0,1'b1, 4'd0, 1'b0,3'd0,8'h06, 4'd5},
    {BN,2'd1,1'b0,1'b1, 4'd1, 1'b0,3'd0,8'h06, 4'd5},
    {BN,2'd1,1'b0,1'b1, 4'd1, 1'b0,3'd0,8'h05, 4'd5},  // R5 back to open
    {BW,2'd0,1'b1,1'b1, 4'd6, 1'b0,3'd0,8'h07, 4'd5},  // R5 write, auto precharge
    {BR,2'd0,1'b0,1'b1, 4'd7, 1'b0,3'd0,8'h06, 4'd6},  // R6 read cuts write
    {BN,2'd0,1'b0,1'b1, 4'd1, 1'b0,3'd0,8'h06, 4'd6},
    {BN,2'd0,1'b0,1'b1, 4'd1, 1'b0,3'd0,8'h06, 4'd6},
    {BN,2'd0,1'b0,1'b1, 4'd1, 1'b0,3'd0,8'h06, 4'd6},
    {BR,2'd0,1'b1,1'b1, 4'd7, 1'b0,3'd0,8'h06, 4'd6},  // R6 read on last beat
    {BN,2'd0,1'b0,1'b1, 4'd1, 1'b0,3'd0,8'h06, 4'd6},
    {BN,2'd0,1'b0,1'b1, 4'd1, 1'b0,3'd0,8'h06, 4'd6},
    {BN,2'd0,1'b0,1'b1, 4'd1, 1'b0,3'd0,8'h06, 4'd6},
    {BN,2'd0,1'b0,1'b1, 4'd1, 1'b0,3'd0,8'h04, 4'd5},  // R5 auto precharge closes
    {BM,2'd0,1'b0,1'b1, 4'd2, 1'b1,3'd2,8'h04, 4'd10}, // R10 mode-set, bank 1 open
    {BF,2'd0,1'b0,1'b1, 4'd3, 1'b1,3'd2,8'h04, 4'd10}, // R10 refresh, bank 1 open
    {BW,2'd1,1'b0,1'b1, 4'd6, 1'b0,3'd0,8'h0C, 4'd5},  // R5 write bank 1
    {BP,2'd1,1'b0,1'b1, 4'd4, 1'b0,3'd0,8'h00, 4'd6},  // R6 precharge ends burst
    {BF,2'd0,1'b0,1'b1, 4'd3, 1'b0,3'd0,8'h00, 4'd10}, // R10 refresh legal
    {BF,2'd0,1'b0,1'b0, 4'd8, 1'b0,3'd0,8'h00, 4'd11}, // R11 self refresh
    {BN,2'd0,1'b0,1'b1, 4'd10,1'b0,3'd0,8'h00, 4'd11}, // R11 suspended cycle
    {BD,2'd0,1'b0,1'b0, 4'd9, 1'b0,3'd0,8'h00, 4'd11}, // R11 power down
    {BA,2'd2,1'b0,1'b1, 4'd10,1'b0,3'd0,8'h00, 4'd11}, // R11 activate ignored
    {BN,2'd0,1'b0,1'b1, 4'd1, 1'b0,3'd0,8'h00, 4'd11},
    {BA,2'd2,1'b0,1'b1, 4'd5, 1'b0,3'd0,8'h10, 4'd4},  // R4 open bank 2
    {BA,2'd3,1'b0,1'b1, 4'd5, 1'b1,3'd5,8'h10, 4'd9},  // R9 spacing violated
    {BA,2'd3,1'b0,1'b1, 4'd5, 1'b0,3'd0,8'h50, 4'd9},  // R9 spacing met
    {BR,2'd2,1'b0,1'b1, 4'd7, 1'b0,3'd0,8'h60, 4'd12}, // R12 other bank irrelevant
    {BW,2'd3,1'b0,1'b1, 4'd6, 1'b1,3'd3,8'h60, 4'd7}   // R7 bank 3 too early
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] bus, input logic [1:0] b,
                       input logic a, input logic ck);
    {cs_n, ras_n, cas_n, we_n} = bus;
    ba = b; a10 = a; cke = ck;
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    drive(BN, 2'd0, 1'b0, 1'b1);
    repeat (3) @(posedge clk);
    #1;
    check("R2 reset states", 32'(bank_state_o), 32'h0);
    check("R2 reset cmd", 32'(cmd_o), 32'h0);
    check("R2 reset flag", 32'(illegal_o), 32'h0);
    check("R2 reset reason", 32'(reason_o), 32'h0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][27:24], VEC[i][23:22], VEC[i][21], VEC[i][20]);
      @(posedge clk);
      #1;
      check($sformatf("R%0d vec %0d {cmd,ill,rsn,st}", VEC[i][3:0], i),
            {16'h0, cmd_o, illegal_o, reason_o, bank_state_o},
            {16'h0, VEC[i][19:4]});
    end

    // R12 flag is a single-cycle pulse; bank 2 burst still running
    @(negedge clk) drive(BN, 2'd0, 1'b0, 1'b1);
    @(posedge clk); #1;
    check("R12 flag drops", 32'(illegal_o), 32'h0);
    check("R12 burst unaffected", 32'(bank_state_o), 32'h60);

    // R2 reset in mid-run closes every bank
    @(negedge clk) rst_n = 1'b0;
    #1;
    check("R2 mid-run reset states", 32'(bank_state_o), 32'h0);
    check("R2 mid-run reset cmd", 32'(cmd_o), 32'h0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    drive(BA, 2'd0, 1'b0, 1'b1);
    @(posedge clk); #1;
    check("R4 activate after reset", {28'h0, cmd_o}, 32'd5);
    check("R4 bank 0 open after reset", 32'(bank_state_o), 32'h01);

    finish_run();
  end

endmodule